// File: doc/BRIEF.md
# Data-Log Transfer Completion Interrupt

This block follows a data-logging transfer as it streams words into a buffer. Software sets a start address and then either a word count or an end address. Writing the count or the end address arms the transfer. Each pulse on the per-word strobe stands for one word written at the current address, and the address then moves forward by one. A mode bit chooses how the transfer ends. In count mode it ends when the word counter runs out. In end-address mode it ends when the word just written sat at the programmed end address.

When the transfer ends, the block disarms itself and sets a sticky pending flag. The flag stays set until an acknowledge pulse clears it. This means a request that is not serviced at once is not lost, and a handler can start the next buffer whenever it gets to it. The request leaves the block only when the enable rules allow it. While the CPU is halted in real-time debug mode, both the debug enable and the normal enable must be set. Otherwise the normal enable must be set and the active-high global mask must be clear.

Top module: `dlog_done_irq`

## Requirements
- R1: After reset, cur_addr, the counter and the end address are zero, the mode is count mode, xfer_active is 0, irq_pend is 0 and irq_req is 0.
- R2: A write with cfg_we=1 uses cfg_sel to pick the target: 0 is the start address, 1 is the word count, 2 is the end address and 3 is the mode, with cfg_wdata[0]=0 for count mode and 1 for end-address mode. A start-address write appears on cur_addr in the next cycle.
- R3: A word strobe while armed, with no write in the same cycle, makes cur_addr one higher in the next cycle, wrapping to zero after the all-ones value.
- R4: In count mode, a count of N greater than zero completes on the Nth accepted word. A count of zero completes on the first accepted word.
- R5: In end-address mode, the transfer completes on the accepted word written while cur_addr equals the end address, so cur_addr ends at the end address plus one.
- R6: Completion clears xfer_active in the next cycle. A strobe while disarmed leaves cur_addr and all flags unchanged.
- R7: Writing the word count or the end address arms the transfer: xfer_active is 1 in the next cycle.
- R8: While rt_halted=1, irq_req equals irq_pend AND ier_en AND dbgier_en.
- R9: While rt_halted=0, irq_req equals irq_pend AND ier_en AND NOT intm, so intm=1 blocks the request.
- R10: Completion sets irq_pend in the next cycle. The flag holds until an irq_ack pulse clears it. If completion and irq_ack fall in the same cycle, the flag ends up set.
- R11: When a configuration write and a word strobe fall in the same cycle, the write takes effect and the strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 start, 1 count, 2 end address, 3 mode |
| cfg_wdata | input | 16 | Write data |
| word_stb | input | 1 | One word transferred at cur_addr |
| rt_halted | input | 1 | CPU halted in real-time debug mode |
| ier_en | input | 1 | Data-log bit of the interrupt enable register |
| dbgier_en | input | 1 | Data-log bit of the debug interrupt enable register |
| intm | input | 1 | Global mask, 1 blocks maskable interrupts |
| irq_ack | input | 1 | Clears the pending flag |
| cur_addr | output | 16 | Address of the next word |
| xfer_active | output | 1 | Transfer armed |
| irq_pend | output | 1 | Completion pending |
| irq_req | output | 1 | Qualified interrupt request |

## Verification
Two things can fall in the same cycle and both touch the pending flag: the final word of a transfer, which sets it, and the acknowledge pulse, which clears it. The bench keeps a flag already pending, then drives the last strobe of a one-word transfer together with irq_ack, and expects irq_pend to stay set. It also drives a configuration write together with a strobe and expects the write to land while the address does not advance. In every cycle the outputs are compared with a behavioural model that applies these priorities.

// File: rtl/dlog_pkg.sv
package dlog_pkg;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_END   = 2'd2,
    SEL_MODE  = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    TERM_COUNT = 1'b0,
    TERM_ADDR  = 1'b1
  } term_e;

endpackage

// File: rtl/dlog_cfg_regs.sv
module dlog_cfg_regs
  import dlog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int WD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WD_W-1:0]   cfg_wdata,
  output logic              start_wr,
  output logic [ADDR_W-1:0] start_val,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              arm,
  output logic [ADDR_W-1:0] end_addr,
  output term_e             mode
);

  cfg_sel_e          sel;
  logic              end_en, mode_en;
  logic [ADDR_W-1:0] end_addr_n;
  term_e             mode_n;

  always_comb begin
    sel        = cfg_sel_e'(cfg_sel);
    start_wr   = cfg_we && (sel == SEL_START);
    cnt_wr     = cfg_we && (sel == SEL_COUNT);
    end_en     = cfg_we && (sel == SEL_END);
    mode_en    = cfg_we && (sel == SEL_MODE);
    arm        = cnt_wr || end_en;
    start_val  = cfg_wdata[ADDR_W-1:0];
    cnt_val    = cfg_wdata[CNT_W-1:0];
    end_addr_n = cfg_wdata[ADDR_W-1:0];
    mode_n     = cfg_wdata[0] ? TERM_ADDR : TERM_COUNT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_addr <= '0;
    end else if (end_en) begin
      end_addr <= end_addr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= TERM_COUNT;
    end else if (mode_en) begin
      mode <= mode_n;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> $stable(mode)); // R2

endmodule

// File: rtl/dlog_xfer_track.sv
module dlog_xfer_track
  import dlog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_busy,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_val,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              arm,
  input  logic [ADDR_W-1:0] end_addr,
  input  term_e             mode,
  input  logic              word_stb,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              active,
  output logic              done
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [ADDR_W-1:0] addr_n;
  logic              active_n;
  logic              take, last_word;
  logic              addr_en, cnt_en, act_en;

  // A word counts only while armed and not colliding with a write.
  always_comb begin
    take      = word_stb && active && !cfg_busy;
    last_word = (mode == TERM_ADDR) ? (cur_addr == end_addr)
                                    : (cnt <= CNT_ONE);
    done      = take && last_word;
  end

  always_comb begin
    addr_en = start_wr || take;
    addr_n  = start_wr ? start_val : cur_addr + ADDR_ONE;
    cnt_en  = cnt_wr || (take && (cnt != '0));
    cnt_n   = cnt_wr ? cnt_val : cnt - CNT_ONE;
    act_en  = arm || done;
    active_n = arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
    end else if (addr_en) begin
      cur_addr <= addr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
    end else if (act_en) begin
      active <= active_n;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && active && !cfg_busy) |=> (cur_addr == $past(cur_addr) + ADDR_ONE)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && !active && !cfg_busy) |=> $stable(cur_addr)); // R6

  AST_DONE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active); // R6

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> active); // R7

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_busy && !start_wr) |=> $stable(cur_addr)); // R11

endmodule

// File: rtl/dlog_irq_qual.sv
module dlog_irq_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic irq_ack,
  input  logic rt_halted,
  input  logic ier_en,
  input  logic dbgier_en,
  input  logic intm,
  output logic pend,
  output logic irq_req
);

  logic pend_en, pend_n;
  logic allow_halted, allow_run;

  always_comb begin
    pend_en = done || irq_ack;
    pend_n  = done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (pend_en) begin
      pend <= pend_n;
    end
  end

  always_comb begin
    allow_halted = ier_en && dbgier_en;
    allow_run    = ier_en && !intm;
    irq_req      = pend && (rt_halted ? allow_halted : allow_run);
  end

  AST_DONE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> pend); // R10

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !irq_ack) |=> pend); // R10

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !done) |=> !pend); // R10

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_halted && intm) |-> !irq_req); // R9

endmodule

// File: rtl/dlog_done_irq.sv
module dlog_done_irq
  import dlog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int WD_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WD_W-1:0]   cfg_wdata,
  input  logic              word_stb,
  input  logic              rt_halted,
  input  logic              ier_en,
  input  logic              dbgier_en,
  input  logic              intm,
  input  logic              irq_ack,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              xfer_active,
  output logic              irq_pend,
  output logic              irq_req
);

  logic              start_wr, cnt_wr, arm, done;
  logic [ADDR_W-1:0] start_val, end_addr;
  logic [CNT_W-1:0]  cnt_val;
  term_e             mode;

  dlog_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WD_W(WD_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .start_wr  (start_wr),
    .start_val (start_val),
    .cnt_wr    (cnt_wr),
    .cnt_val   (cnt_val),
    .arm       (arm),
    .end_addr  (end_addr),
    .mode      (mode)
  );

  dlog_xfer_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_busy  (cfg_we),
    .start_wr  (start_wr),
    .start_val (start_val),
    .cnt_wr    (cnt_wr),
    .cnt_val   (cnt_val),
    .arm       (arm),
    .end_addr  (end_addr),
    .mode      (mode),
    .word_stb  (word_stb),
    .cur_addr  (cur_addr),
    .active    (xfer_active),
    .done      (done)
  );

  dlog_irq_qual u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .irq_ack   (irq_ack),
    .rt_halted (rt_halted),
    .ier_en    (ier_en),
    .dbgier_en (dbgier_en),
    .intm      (intm),
    .pend      (irq_pend),
    .irq_req   (irq_req)
  );

  AST_HALT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_halted && !dbgier_en) |-> !irq_req); // R8

endmodule

// File: tb/dlog_done_irq_bench.sv
module dlog_done_irq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, word_stb, rt_halted, ier_en, dbgier_en, intm, irq_ack;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic [15:0] cur_addr;
  logic        xfer_active, irq_pend, irq_req;

  int n_checks = 0;
  int n_fail   = 0;
  string tag = "R1";

  // behavioural reference state
  int m_addr, m_cnt, m_end, m_mode, m_act, m_pend;

  always #2.5 clk = ~clk;

  dlog_done_irq u_dlog_done_irq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .word_stb(word_stb), .rt_halted(rt_halted),
    .ier_en(ier_en), .dbgier_en(dbgier_en), .intm(intm), .irq_ack(irq_ack),
    .cur_addr(cur_addr), .xfer_active(xfer_active), .irq_pend(irq_pend),
    .irq_req(irq_req)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int a, c, act, p, tk, dn;
    if (!rst_n) begin
      m_addr = 0; m_cnt = 0; m_end = 0; m_mode = 0; m_act = 0; m_pend = 0;
    end else begin
      a = m_addr; c = m_cnt; act = m_act; p = m_pend;
      tk = (word_stb && m_act && !cfg_we) ? 1 : 0;
      dn = 0;
      if (tk) dn = (m_mode == 1) ? (m_addr == m_end) : (m_cnt <= 1);
      if (tk) begin
        a = (m_addr + 1) % 65536;
        if (m_cnt > 0) c = m_cnt - 1;
      end
      if (dn) act = 0;
      if (irq_ack) p = 0;
      if (dn) p = 1;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: a = cfg_wdata;
          2'd1: begin c = cfg_wdata; act = 1; end
          2'd2: begin m_end = cfg_wdata; act = 1; end
          default: m_mode = cfg_wdata[0];
        endcase
      end
      m_addr = a; m_cnt = c; m_act = act; m_pend = p;
    end
  end

  always @(negedge clk) begin
    int ereq;
    if (rst_n) begin
      ereq = m_pend && (rt_halted ? (ier_en && dbgier_en) : (ier_en && !intm));
      check(tag, "cur_addr", cur_addr, m_addr);
      check(tag, "xfer_active", xfer_active, m_act);
      check(tag, "irq_pend", irq_pend, m_pend);
      check(tag, "irq_req", irq_req, ereq);
    end
  end

  task automatic step(logic stb, logic ack);
    @(negedge clk); #1;
    cfg_we = 1'b0; word_stb = stb; irq_ack = ack;
  endtask

  task automatic wr(int sel, int data, logic stb);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = data[15:0];
    word_stb = stb; irq_ack = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; word_stb = 0;
    rt_halted = 0; ier_en = 1; dbgier_en = 0; intm = 0; irq_ack = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "cur_addr", cur_addr, 0);
    check("R1", "xfer_active", xfer_active, 0);
    check("R1", "irq_pend", irq_pend, 0);
    check("R1", "irq_req", irq_req, 0);
    #1 rst_n = 1'b1;

    tag = "R6"; run(2);                      // strobes while disarmed ignored
    tag = "R2"; wr(0, 16'h0010, 0); step(0, 0);
    check("R2", "start loaded", cur_addr, 16'h0010);
    tag = "R4"; wr(1, 3, 0); run(5);         // count of three
    check("R4", "addr after count", cur_addr, 16'h0013);
    check("R10", "pending after done", irq_pend, 1);
    tag = "R10"; step(0, 0); step(0, 1); step(0, 0);
    check("R10", "ack clears", irq_pend, 0);

    tag = "R4"; wr(1, 0, 0); run(3);         // zero count: first word ends it
    check("R4", "zero count addr", cur_addr, 16'h0014);
    step(0, 1);

    tag = "R5"; wr(3, 1, 0); wr(0, 16'h0020, 0); wr(2, 16'h0022, 0); run(6);
    check("R5", "end addr stop", cur_addr, 16'h0023);
    check("R6", "disarmed", xfer_active, 0);

    // R8 / R9: enable rules swept with a pending flag held
    for (int i = 0; i < 16; i++) begin
      tag = (i >= 8) ? "R8" : "R9";
      @(negedge clk); #1;
      {rt_halted, ier_en, dbgier_en, intm} = i[3:0];
      step(0, 0);
    end
    rt_halted = 0; ier_en = 1; intm = 0;

    // R10: completion and ack in the same cycle, flag already set
    tag = "R10"; wr(3, 0, 0); wr(1, 1, 0); step(1, 1); step(0, 0);
    check("R10", "done beats ack", irq_pend, 1);
    step(0, 1);

    // R11: write collides with a strobe
    tag = "R11"; wr(1, 4, 0); wr(0, 16'h0100, 1); step(0, 0);
    check("R11", "write wins", cur_addr, 16'h0100);
    wr(2, 16'h0200, 1); step(0, 0);
    check("R11", "strobe ignored", cur_addr, 16'h0100);

    // R3: wrap, R7: rearm
    tag = "R3"; wr(0, 16'hFFFF, 0); wr(1, 2, 0); step(0, 0);
    check("R7", "armed", xfer_active, 1);
    run(2);
    check("R3", "wrap", cur_addr, 16'h0001);
    step(0, 1); step(0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule